// File: doc/BRIEF.md
# Pointer Aperture Converter

The block takes a memory pointer from a scalar load or a flat vector access and turns it into a 48-bit virtual address and one translation-select bit. The select bit (ATC) chooses between the host page tables (1) and the device page tables (0). The block also chooses a memory-type code for cache policy. It raises a violation flag when the request cannot be served as issued.

Three address modes exist, decoded from the request's flags:
- **HSA64**: 64-bit pointers, default space host.
- **HSA32**: 32-bit pointers, default space host.
- **GPUVM64**: 64-bit pointers, default space device.

Two programmable apertures are compared against the pointer:
- **Device aperture**: requests that land in it are rebased to its start and sent to the device tables.
- **Spare aperture**: requests that land in it only change the memory type.

Addresses outside the canonical 64-bit range form a hole. A request whose first byte or last byte falls in the hole, outside both apertures, is flagged. A payload whose first and last bytes resolve to different regions is also flagged. The result is registered and appears one clock after the request.

Top module: `ptr_aperture_xlate`

## Requirements
- R1: Mode decode is as follows. dispAtc=1 with ptr32=0 is HSA64 (default ATC=1). dispAtc=1 with ptr32=1 is HSA32 (default ATC=1). dispAtc=0 is GPUVM64 (default ATC=0), and in that mode ptr32 is ignored and all 64 pointer bits are used.
- R2: A draw request (isCompute=0) is handled in GPUVM64 mode whatever dispAtc and ptr32 are.
- R3: An aperture register holds address bits [63:16]. The base is that value with bits [15:0] zero, and the limit is that value with bits [15:0] all ones. Both ends are inside the aperture. An aperture whose base register exceeds its limit register is empty.
- R4: A start address inside the device aperture gives outAddr = (address − device base)[47:0] and outAtc=0.
- R5: A start address in no aperture gives outAddr = address[47:0] and outAtc equal to the mode's default space.
- R6: A start address inside the spare aperture gives outMtype = spareMtype, with outAddr and outAtc as in R5. Otherwise outMtype = defMtype. The spare aperture never matches in HSA32 mode. The device aperture has priority over the spare aperture.
- R7: outViol=1 when the first or last byte is non-canonical (bits [63:47] neither all zeros nor all ones) and inside no aperture.
- R8: The last byte is start + size − 1, where a size of 0 counts as 1. outViol=1 when the first and last bytes fall in different regions (device, spare, default, hole).
- R9: In HSA32 mode the pointer's bits [63:32] are replaced by zeros before any comparison or output.
- R10: Each accepted request produces outValid=1 exactly one clock later. Without a request, outValid=0 and outAddr, outAtc, outMtype and outViol keep their values. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqPtr | input | 64 | Pointer from the request |
| reqSize | input | SIZE_W | Payload size in bytes (0 counts as 1) |
| isCompute | input | 1 | 1 = compute request, 0 = draw request |
| dispAtc | input | 1 | Dispatch default-space flag |
| ptr32 | input | 1 | 32-bit pointer flag |
| vmBaseReg | input | 48 | Device aperture base bits [63:16] |
| vmLimitReg | input | 48 | Device aperture limit bits [63:16] |
| spareBaseReg | input | 48 | Spare aperture base bits [63:16] |
| spareLimitReg | input | 48 | Spare aperture limit bits [63:16] |
| spareMtype | input | MT_W | Memory type for spare-aperture hits |
| defMtype | input | MT_W | Memory type for all other requests |
| outValid | output | 1 | Result strobe |
| outAddr | output | 48 | Converted virtual address |
| outAtc | output | 1 | 1 = host tables, 0 = device tables |
| outMtype | output | MT_W | Selected memory type |
| outViol | output | 1 | Memory violation flag |

## Verification
The hardest case to reach is a straddle: the first byte must lie in one region and the last byte in another. This needs a pointer a few bytes below an aperture edge together with a size that crosses it. The table places pointers exactly at, just inside and just past the device and spare limits, and pairs them with sizes that stay inside or cross the edge. A dedicated vector with a size of 0 checks that a zero size is read as one byte. The spare-aperture exclusion in HSA32 is reached by moving the spare aperture into the low 4 GiB in a directed test. The same pointer is then issued in both 32-bit and 64-bit modes.

// File: rtl/ptr_aperture_pkg.sv
package ptr_aperture_pkg;

  localparam int ADDR_W  = 64;
  localparam int VA_W    = 48;
  localparam int GRAN_W  = 16;
  localparam int REG_W   = ADDR_W - GRAN_W;
  localparam int CANON_LO = 47;

  typedef enum logic [1:0] {
    RGN_DEFAULT = 2'd0,
    RGN_DEVICE  = 2'd1,
    RGN_SPARE   = 2'd2,
    RGN_HOLE    = 2'd3
  } region_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic defAtc;
    logic use32;
    logic vmEn;
    logic spareEn;
  } ctrl_s;

endpackage

// File: rtl/ptr_aperture_class.sv
module ptr_aperture_class
  import ptr_aperture_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] vmBase,
  input  logic [ADDR_W-1:0] vmLimit,
  input  logic [ADDR_W-1:0] spareBase,
  input  logic [ADDR_W-1:0] spareLimit,
  input  logic              vmEn,
  input  logic              spareEn,
  output region_e           region
);

  localparam int TOP_N = ADDR_W - CANON_LO;

  logic vmHit;
  logic spareHit;
  logic canonical;

  assign vmHit     = vmEn && (addr >= vmBase) && (addr <= vmLimit);
  assign spareHit  = spareEn && (addr >= spareBase) && (addr <= spareLimit);
  assign canonical = (addr[ADDR_W-1:CANON_LO] == {TOP_N{1'b0}}) ||
                     (addr[ADDR_W-1:CANON_LO] == {TOP_N{1'b1}});

  always_comb begin
    if (vmHit)           region = RGN_DEVICE;
    else if (spareHit)   region = RGN_SPARE;
    else if (!canonical) region = RGN_HOLE;
    else                 region = RGN_DEFAULT;
  end

endmodule

// File: rtl/ptr_aperture_ctrl.sv
module ptr_aperture_ctrl
  import ptr_aperture_pkg::*;
(
  input  logic             reqValid,
  input  logic             isCompute,
  input  logic             dispAtc,
  input  logic             ptr32,
  input  logic [REG_W-1:0] vmBaseReg,
  input  logic [REG_W-1:0] vmLimitReg,
  input  logic [REG_W-1:0] spareBaseReg,
  input  logic [REG_W-1:0] spareLimitReg,
  output ctrl_s            ctrl
);

  typedef enum logic [1:0] {MODE_GPUVM64, MODE_HSA64, MODE_HSA32} mode_e;

  mode_e mode;

  always_comb begin
    if (!isCompute || !dispAtc) mode = MODE_GPUVM64;
    else if (ptr32)             mode = MODE_HSA32;
    else                        mode = MODE_HSA64;
  end

  always_comb begin
    ctrl.load    = reqValid;
    ctrl.defAtc  = (mode != MODE_GPUVM64);
    ctrl.use32   = (mode == MODE_HSA32);
    ctrl.vmEn    = (vmBaseReg <= vmLimitReg);
    ctrl.spareEn = (mode != MODE_HSA32) && (spareBaseReg <= spareLimitReg);
  end

endmodule

// File: rtl/ptr_aperture_dp.sv
module ptr_aperture_dp
  import ptr_aperture_pkg::*;
#(
  parameter int SIZE_W = 5,
  parameter int MT_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_s             ctrl,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqPtr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [REG_W-1:0]  vmBaseReg,
  input  logic [REG_W-1:0]  vmLimitReg,
  input  logic [REG_W-1:0]  spareBaseReg,
  input  logic [REG_W-1:0]  spareLimitReg,
  input  logic [MT_W-1:0]   spareMtype,
  input  logic [MT_W-1:0]   defMtype,
  output logic              outValid,
  output logic [VA_W-1:0]   outAddr,
  output logic              outAtc,
  output logic [MT_W-1:0]   outMtype,
  output logic              outViol
);

  localparam int HALF_W = ADDR_W / 2;
  localparam int NPROBE = 2;   // first byte, last byte

  logic [ADDR_W-1:0] vmBase, vmLimit, spareBase, spareLimit;
  logic [ADDR_W-1:0] extPtr, lastPtr, rebased;
  logic [SIZE_W-1:0] effSize;
  logic [ADDR_W-1:0] probe [NPROBE];
  region_e           rgn   [NPROBE];

  logic [VA_W-1:0]   nxtAddr;
  logic              nxtAtc;
  logic [MT_W-1:0]   nxtMtype;
  logic              nxtViol;

  assign vmBase     = {vmBaseReg,     {GRAN_W{1'b0}}};
  assign vmLimit    = {vmLimitReg,    {GRAN_W{1'b1}}};
  assign spareBase  = {spareBaseReg,  {GRAN_W{1'b0}}};
  assign spareLimit = {spareLimitReg, {GRAN_W{1'b1}}};

  assign extPtr  = ctrl.use32 ? {{HALF_W{1'b0}}, reqPtr[HALF_W-1:0]} : reqPtr;
  assign effSize = (reqSize == '0) ? SIZE_W'(1) : reqSize;
  assign lastPtr = extPtr + ADDR_W'(effSize) - ADDR_W'(1);
  assign rebased = extPtr - vmBase;

  assign probe[0] = extPtr;
  assign probe[1] = lastPtr;

  for (genvar g = 0; g < NPROBE; g++) begin : gProbe
    ptr_aperture_class u_class (
      .addr       (probe[g]),
      .vmBase     (vmBase),
      .vmLimit    (vmLimit),
      .spareBase  (spareBase),
      .spareLimit (spareLimit),
      .vmEn       (ctrl.vmEn),
      .spareEn    (ctrl.spareEn),
      .region     (rgn[g])
    );
  end

  always_comb begin
    nxtAddr  = extPtr[VA_W-1:0];
    nxtAtc   = ctrl.defAtc;
    nxtMtype = defMtype;
    case (rgn[0])
      RGN_DEVICE: begin
        nxtAddr = rebased[VA_W-1:0];
        nxtAtc  = 1'b0;
      end
      RGN_SPARE: nxtMtype = spareMtype;
      default: ;
    endcase
    nxtViol = (rgn[0] == RGN_HOLE) || (rgn[1] == RGN_HOLE) || (rgn[0] != rgn[1]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outAddr  <= '0;
      outAtc   <= 1'b0;
      outMtype <= '0;
      outViol  <= 1'b0;
    end else begin
      outValid <= reqValid;
      if (ctrl.load) begin
        outAddr  <= nxtAddr;
        outAtc   <= nxtAtc;
        outMtype <= nxtMtype;
        outViol  <= nxtViol;
      end
    end
  end

endmodule

// File: rtl/ptr_aperture_xlate.sv
module ptr_aperture_xlate
  import ptr_aperture_pkg::*;
#(
  parameter int SIZE_W = 5,
  parameter int MT_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [63:0]       reqPtr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              isCompute,
  input  logic              dispAtc,
  input  logic              ptr32,
  input  logic [47:0]       vmBaseReg,
  input  logic [47:0]       vmLimitReg,
  input  logic [47:0]       spareBaseReg,
  input  logic [47:0]       spareLimitReg,
  input  logic [MT_W-1:0]   spareMtype,
  input  logic [MT_W-1:0]   defMtype,
  output logic              outValid,
  output logic [47:0]       outAddr,
  output logic              outAtc,
  output logic [MT_W-1:0]   outMtype,
  output logic              outViol
);

  ctrl_s ctrl;

  ptr_aperture_ctrl u_ctrl (
    .reqValid      (reqValid),
    .isCompute     (isCompute),
    .dispAtc       (dispAtc),
    .ptr32         (ptr32),
    .vmBaseReg     (vmBaseReg),
    .vmLimitReg    (vmLimitReg),
    .spareBaseReg  (spareBaseReg),
    .spareLimitReg (spareLimitReg),
    .ctrl          (ctrl)
  );

  ptr_aperture_dp #(.SIZE_W(SIZE_W), .MT_W(MT_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctrl          (ctrl),
    .reqValid      (reqValid),
    .reqPtr        (reqPtr),
    .reqSize       (reqSize),
    .vmBaseReg     (vmBaseReg),
    .vmLimitReg    (vmLimitReg),
    .spareBaseReg  (spareBaseReg),
    .spareLimitReg (spareLimitReg),
    .spareMtype    (spareMtype),
    .defMtype      (defMtype),
    .outValid      (outValid),
    .outAddr       (outAddr),
    .outAtc        (outAtc),
    .outMtype      (outMtype),
    .outViol       (outViol)
  );

endmodule

// File: rtl/ptr_aperture_chk.sv
module ptr_aperture_chk #(
  parameter int MT_W = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            isCompute,
  input logic            dispAtc,
  input logic            ptr32,
  input logic [MT_W-1:0] defMtype,
  input logic            outValid,
  input logic [47:0]     outAddr,
  input logic            outAtc,
  input logic [MT_W-1:0] outMtype,
  input logic            outViol
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);                                            // R10

  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !outValid);                                          // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(outAddr) && $stable(outAtc) &&
                   $stable(outMtype) && $stable(outViol)));            // R10

  AST_DRAW_DEVICE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !isCompute) |=> !outAtc);                             // R2

  AST_GPUVM_DEVICE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !dispAtc) |=> !outAtc);                               // R1

  AST_NARROW_MTYPE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && isCompute && dispAtc && ptr32) |=> (outMtype == $past(defMtype))); // R6

endmodule

bind ptr_aperture_xlate ptr_aperture_chk #(.MT_W(MT_W)) u_chk (.*);

// File: tb/ptr_aperture_xlate_bench.sv
module ptr_aperture_xlate_bench;

  localparam int SIZE_W = 5;
  localparam int MT_W   = 2;
  localparam int NVEC   = 18;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [63:0]       reqPtr = '0;
  logic [SIZE_W-1:0] reqSize = '0;
  logic              isCompute = 1'b0, dispAtc = 1'b0, ptr32 = 1'b0;
  logic [47:0]       vmBaseReg, vmLimitReg, spareBaseReg, spareLimitReg;
  logic [MT_W-1:0]   spareMtype, defMtype;
  logic              outValid, outAtc, outViol;
  logic [47:0]       outAddr;
  logic [MT_W-1:0]   outMtype;

  int nRun = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  ptr_aperture_xlate #(.SIZE_W(SIZE_W), .MT_W(MT_W)) u_ptr_aperture_xlate (.*);

  // ctl = {isCompute, dispAtc, ptr32}; req = requirement number shown in FAIL lines
  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  ctl;
    logic [63:0] ptr;
    logic [4:0]  size;
    logic [47:0] addr;
    logic        atc;
    logic [1:0]  mt;
    logic        viol;
  } vec_s;

  // Device aperture 0x8000_0000_0000_0000..0x8000_00FF_FFFF_FFFF (in the hole)
  // Spare aperture  0x0000_1000_0000_0000..0x0000_1000_FFFF_FFFF; defMtype 1, spareMtype 3
  localparam vec_s VECS [NVEC] = '{
    '{4'd5, 3'b110, 64'h0000_0000_1234_5678, 5'd4, 48'h0000_1234_5678, 1'b1, 2'd1, 1'b0}, // R5 R1 HSA64 default
    '{4'd4, 3'b110, 64'h8000_0000_0000_1000, 5'd8, 48'h0000_0000_1000, 1'b0, 2'd1, 1'b0}, // R4 device hit
    '{4'd3, 3'b110, 64'h8000_00FF_FFFF_FFFF, 5'd1, 48'h00FF_FFFF_FFFF, 1'b0, 2'd1, 1'b0}, // R3 limit inclusive
    '{4'd3, 3'b110, 64'h8000_0000_0000_0000, 5'd1, 48'h0000_0000_0000, 1'b0, 2'd1, 1'b0}, // R3 base inclusive
    '{4'd7, 3'b110, 64'h8000_0100_0000_0000, 5'd1, 48'h0100_0000_0000, 1'b1, 2'd1, 1'b1}, // R7 past limit, hole
    '{4'd6, 3'b110, 64'h0000_1000_0000_0040, 5'd4, 48'h1000_0000_0040, 1'b1, 2'd3, 1'b0}, // R6 spare hit
    '{4'd6, 3'b110, 64'h0000_0FFF_FFFF_FFFC, 5'd4, 48'h0FFF_FFFF_FFFC, 1'b1, 2'd1, 1'b0}, // R6 just below spare
    '{4'd8, 3'b110, 64'h0000_0FFF_FFFF_FFFC, 5'd8, 48'h0FFF_FFFF_FFFC, 1'b1, 2'd1, 1'b1}, // R8 straddle into spare
    '{4'd5, 3'b110, 64'hFFFF_8000_0000_0000, 5'd4, 48'h8000_0000_0000, 1'b1, 2'd1, 1'b0}, // R5 high canonical
    '{4'd7, 3'b110, 64'h0000_8000_0000_0000, 5'd4, 48'h8000_0000_0000, 1'b1, 2'd1, 1'b1}, // R7 hole
    '{4'd1, 3'b101, 64'h0000_0001_0000_0000, 5'd4, 48'h0001_0000_0000, 1'b0, 2'd1, 1'b0}, // R1 GPUVM64 ignores ptr32
    '{4'd2, 3'b011, 64'h0000_0001_0000_0000, 5'd4, 48'h0001_0000_0000, 1'b0, 2'd1, 1'b0}, // R2 draw forced GPUVM64
    '{4'd9, 3'b111, 64'hDEAD_BEEF_0000_1000, 5'd4, 48'h0000_0000_1000, 1'b1, 2'd1, 1'b0}, // R9 HSA32 zero-extend
    '{4'd8, 3'b110, 64'h8000_00FF_FFFF_FFFE, 5'd4, 48'h00FF_FFFF_FFFE, 1'b0, 2'd1, 1'b1}, // R8 device into hole
    '{4'd8, 3'b110, 64'h0000_0FFF_FFFF_FFFF, 5'd0, 48'h0FFF_FFFF_FFFF, 1'b1, 2'd1, 1'b0}, // R8 size 0 as 1
    '{4'd8, 3'b110, 64'h0000_0FFF_FFFF_FFFF, 5'd2, 48'h0FFF_FFFF_FFFF, 1'b1, 2'd1, 1'b1}, // R8 size 2 crosses
    '{4'd7, 3'b100, 64'h0000_8000_0000_0000, 5'd4, 48'h8000_0000_0000, 1'b0, 2'd1, 1'b1}, // R7 GPUVM64 hole
    '{4'd4, 3'b100, 64'h8000_0000_00AB_CDE0, 5'd16, 48'h0000_00AB_CDE0, 1'b0, 2'd1, 1'b0} // R4 GPUVM64 device
  };

  task automatic check(input int req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] ctl, input logic [63:0] ptr, input logic [4:0] size);
    @(negedge clk);
    {isCompute, dispAtc, ptr32} = ctl;
    reqPtr   = ptr;
    reqSize  = size;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    vmBaseReg     = 48'h8000_0000_0000;
    vmLimitReg    = 48'h8000_00FF_FFFF;
    spareBaseReg  = 48'h0000_1000_0000;
    spareLimitReg = 48'h0000_1000_FFFF;
    spareMtype    = 2'd3;
    defMtype      = 2'd1;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(10, "reset outValid", 64'(outValid), 64'd0);
    check(10, "reset outAddr", 64'(outAddr), 64'd0);
    check(10, "reset outViol", 64'(outViol), 64'd0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      issue(VECS[i].ctl, VECS[i].ptr, VECS[i].size);
      check(10, "outValid", 64'(outValid), 64'd1);
      check(int'(VECS[i].req), "outAddr", 64'(outAddr), 64'(VECS[i].addr));
      check(int'(VECS[i].req), "outAtc", 64'(outAtc), 64'(VECS[i].atc));
      check(int'(VECS[i].req), "outMtype", 64'(outMtype), 64'(VECS[i].mt));
      check(int'(VECS[i].req), "outViol", 64'(outViol), 64'(VECS[i].viol));
    end

    // R10 idle cycle: inputs change without reqValid, outputs hold
    reqPtr = 64'h0000_8000_0000_0000;
    {isCompute, dispAtc, ptr32} = 3'b110;
    @(negedge clk);
    check(10, "idle outValid", 64'(outValid), 64'd0);
    check(10, "idle outAddr", 64'(outAddr), 64'h8000_0000_00AB_CDE0 & 64'h0000_FFFF_FFFF_FFFF);
    check(10, "idle outViol", 64'(outViol), 64'd0);

    // R6 spare moved into low 4 GiB: hit in HSA64, ignored in HSA32
    spareBaseReg  = 48'h0000_0000_0001;
    spareLimitReg = 48'h0000_0000_0001;
    issue(3'b110, 64'h0000_0000_0001_0010, 5'd4);
    check(6, "HSA64 low spare mtype", 64'(outMtype), 64'd3);
    issue(3'b111, 64'h0000_0000_0001_0010, 5'd4);
    check(6, "HSA32 spare ignored mtype", 64'(outMtype), 64'd1);
    check(6, "HSA32 spare ignored viol", 64'(outViol), 64'd0);
    check(6, "HSA32 spare ignored atc", 64'(outAtc), 64'd1);

    // R3 empty device aperture (base reg above limit reg): no rebase
    vmBaseReg  = 48'h8000_0100_0000;
    vmLimitReg = 48'h8000_0000_FFFF;
    issue(3'b110, 64'h8000_0100_0000_0000, 5'd1);
    check(3, "empty aperture viol", 64'(outViol), 64'd1);
    check(3, "empty aperture atc", 64'(outAtc), 64'd1);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule